// File: doc/BRIEF.md
# Saturating BIP-8 Parity Error Counter

This block watches a byte stream that is split into frames. For every frame it folds the bytes together into an 8-bit even parity value, known as BIP-8. During the following frame it compares that value with the parity byte the far end sent. Each mismatch is added to a 16-bit running error counter. A periodic latch strobe moves the running total into a readable register and restarts the count, so a slow reader loses nothing.

The counter can add the number of differing parity bits, or it can add one for each frame whose parity byte is wrong. It saturates at its maximum value rather than wrapping to zero. While the line is out of frame, both counts are forced to zero. When the block is built for path use, they are also forced to zero during loss of pointer. After either condition ends, no parity byte is checked until one whole frame has been seen.

Top module: `bip8_err_counter`

## Requirements
- R1: The parity of a frame is the XOR of every accepted byte, starting at the frame-start byte and ending at the byte before the next frame-start byte. The parity byte itself is included. The parity byte that arrives in the next frame is compared against this value.
- R2: With `blk_mode` = 0, one mismatching parity byte adds the number of differing bit positions (0 to 8) to the running count.
- R3: With `blk_mode` = 1, one mismatching parity byte adds exactly 1 to the running count.
- R4: `frame_err` is high for exactly one cycle, the cycle after a checked parity byte that mismatched. It is low at all other times.
- R5: The running count stops at 65535 and never wraps.
- R6: On a `latch_stb` cycle, `latched_cnt` takes the running count as it stood before that cycle. The running count restarts from only the errors of the strobe cycle, so those errors are neither lost nor counted twice.
- R7: While `oof` is high, the running count and `latched_cnt` are held at zero and `frame_err` stays low.
- R8: With the default `PATH_MODE` = 1, `lop` has the same holding effect as `oof`.
- R9: After a hold ends, no parity byte is checked until a complete frame, from one frame-start byte to the next, has been observed with no hold. Parity bytes before that point never count, even when they are wrong.
- R10: After reset, `latched_cnt` is 0, `frame_err` is 0 and the running count is 0.
- R11: Cycles with `byte_vld` low change neither the parity nor the count, whatever `byte_in`, `frame_start` or `bip_mark` carry.

Ports are listed in the order of the top module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | `byte_in` carries a stream byte this cycle |
| byte_in | input | 8 | Stream byte |
| frame_start | input | 1 | This byte is the first byte of a frame |
| bip_mark | input | 1 | This byte is the received parity of the previous frame |
| oof | input | 1 | Out-of-frame condition |
| lop | input | 1 | Loss-of-pointer condition |
| blk_mode | input | 1 | 0 counts errored bits, 1 counts errored frames |
| latch_stb | input | 1 | Copies the running count to `latched_cnt` |
| latched_cnt | output | 16 | Latched error count |
| frame_err | output | 1 | One-cycle pulse after a mismatching parity byte |

## Verification
The parity check is first driven with random frames. In these frames the parity byte is sometimes correct and sometimes XORed with a random mask, and idle cycles carry junk bytes. This separates correct accumulation (R1, R11) from popcount weighting in bit mode and unit weighting in block mode. Directed runs place a strobe exactly on an errored parity byte, which exposes double counting or lost counts. Thousands of all-bits-wrong frames drive the count into saturation. Out-of-frame and loss-of-pointer episodes begin mid-frame and are followed by a deliberately wrong parity byte, which shows whether the first partial frame after the hold is wrongly checked.

// File: rtl/bip8_err_counter.sv
module bip8_err_counter #(
  parameter int CNT_W     = 16,
  parameter bit PATH_MODE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic [7:0]       byte_in,
  input  logic             frame_start,
  input  logic             bip_mark,
  input  logic             oof,
  input  logic             lop,
  input  logic             blk_mode,
  input  logic             latch_stb,
  output logic [CNT_W-1:0] latched_cnt,
  output logic             frame_err
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [7:0]       acc, ref_par, mism;
  logic             acc_ok, ref_ok, hold, chk;
  logic [3:0]       nbits, inc;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] run_cnt, run_nxt;

  assign hold = oof | (PATH_MODE & lop);
  assign chk  = byte_vld & bip_mark & ref_ok & ~hold;
  assign mism = byte_in ^ ref_par;

  always_comb begin
    nbits = '0;
    for (int i = 0; i < 8; i++) nbits = nbits + {3'b000, mism[i]};
  end

  assign inc     = !chk ? 4'd0 : (blk_mode ? {3'b000, |mism} : nbits);
  assign sum     = {1'b0, run_cnt} + (CNT_W+1)'(inc);
  assign run_nxt = latch_stb ? CNT_W'(inc) : (sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      acc_ok  <= 1'b0;
      ref_par <= '0;
      ref_ok  <= 1'b0;
    end else begin
      if (byte_vld) begin
        acc <= frame_start ? byte_in : (acc ^ byte_in);
        if (frame_start) begin
          ref_par <= acc;
          ref_ok  <= acc_ok & ~hold;
        end
      end
      if (hold) begin
        acc_ok <= 1'b0;
        ref_ok <= 1'b0;
      end else if (byte_vld && frame_start) begin
        acc_ok <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      run_cnt     <= '0;
      latched_cnt <= '0;
      frame_err   <= 1'b0;
    end else begin
      run_cnt   <= run_nxt;
      frame_err <= (inc != 4'd0);
      if (latch_stb) latched_cnt <= run_cnt;
    end
  end

  a_r7_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (latched_cnt == '0) && (run_cnt == '0) && !frame_err);

  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_stb && !hold) |=> run_cnt >= $past(run_cnt));

  a_r2_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_mode && !latch_stb && !hold) |=> (run_cnt - $past(run_cnt)) <= CNT_W'(8));

  a_r3_blk_step: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_mode && !latch_stb && !hold) |=> (run_cnt - $past(run_cnt)) <= CNT_W'(1));

  a_r6_latch_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_stb && !hold) |=> latched_cnt == $past(run_cnt));

  a_r4_err_after_bip: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(byte_vld && bip_mark));

  a_r9_no_check_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && bip_mark && !ref_ok && !latch_stb) |=> run_cnt == $past(run_cnt) || $past(hold));

endmodule

// File: tb/bip8_err_counter_test.sv
module bip8_err_counter_test;
  logic clk = 0, rst_n = 0;
  logic byte_vld = 0, frame_start = 0, bip_mark = 0, oof = 0, lop = 0, blk_mode = 0, latch_stb = 0;
  logic [7:0] byte_in = 0;
  logic [15:0] latched_cnt;
  logic frame_err;

  bip8_err_counter uut (.clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
    .frame_start(frame_start), .bip_mark(bip_mark), .oof(oof), .lop(lop), .blk_mode(blk_mode),
    .latch_stb(latch_stb), .latched_cnt(latched_cnt), .frame_err(frame_err));

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] m_acc = 0, m_ref = 0;
  bit m_accv = 0, m_refv = 0, m_ferr = 0;
  int m_run = 0, m_lat = 0;

  function automatic int popc(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += v[i];
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit vld, input bit fs, input bit bm, input logic [7:0] b, input bit stb);
    bit hold;
    int inc;
    byte_vld = vld; frame_start = fs; bip_mark = bm; byte_in = b; latch_stb = stb;
    hold = oof | lop;
    inc = 0;
    if (vld && bm && m_refv && !hold)
      inc = blk_mode ? int'((b ^ m_ref) != 0) : popc(b ^ m_ref);
    if (vld) begin
      if (fs) begin m_ref = m_acc; m_refv = m_accv && !hold; m_acc = b; end
      else m_acc = m_acc ^ b;
    end
    if (hold) begin m_accv = 0; m_refv = 0; end
    else if (vld && fs) m_accv = 1;
    if (hold) begin m_run = 0; m_lat = 0; m_ferr = 0; end
    else begin
      m_ferr = (inc != 0);
      if (stb) begin m_lat = m_run; m_run = inc; end
      else m_run = (m_run + inc > 65535) ? 65535 : m_run + inc;
    end
    @(posedge clk); @(negedge clk);
    if (vld && bm) check(frame_err == m_ferr, blk_mode ? "R3/R4 frame_err" : "R2/R4 frame_err", frame_err, m_ferr);
    else check(frame_err == 0, "R4 frame_err idle", frame_err, 0);
    if (stb) check(latched_cnt == m_lat, blk_mode ? "R6/R3 latch" : "R6/R2 latch", latched_cnt, m_lat);
    if (hold) check(latched_cnt == 0, oof ? "R7 oof hold" : "R8 lop hold", latched_cnt, 0);
  endtask

  // frame of 4 bytes; parity byte at index 1 = prior parity ^ mask
  task automatic frame(input logic [7:0] mask, input int stb_pos, input bit idles);
    for (int i = 0; i < 4; i++) begin
      if (idles && ($urandom % 3 == 0))
        step(0, $urandom % 2, $urandom % 2, 8'($urandom), 0);
      if (i == 1) step(1, 0, 1, m_ref ^ mask, stb_pos == 1);
      else step(1, i == 0, 0, 8'($urandom), stb_pos == i);
    end
  endtask

  task automatic latch_now(input string req);
    step(0, 0, 0, 8'h00, 1);
    check(latched_cnt == m_lat, req, latched_cnt, m_lat);
  endtask

  initial begin
    void'($urandom(32'h5EED_0B18));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(latched_cnt == 0 && frame_err == 0, "R10 reset", latched_cnt, 0);
    latch_now("R10 reset running count");

    // R1/R2: arm, then known bit errors
    frame(0, -1, 0); frame(0, -1, 0);
    frame(8'h05, -1, 0); frame(8'h80, -1, 0);
    latch_now("R2 bit count 3");
    check(m_lat == 3, "R1 model parity", m_lat, 3);
    // R3 block mode
    blk_mode = 1; frame(8'hFF, -1, 0); frame(8'h10, -1, 0); frame(0, -1, 0);
    latch_now("R3 block count 2");
    // R6 strobe on errored parity byte
    blk_mode = 0; frame(8'h0F, 1, 0); latch_now("R6 strobe-cycle errors kept");
    // R11 junk on idle cycles
    for (int k = 0; k < 20; k++) frame(($urandom % 2) ? 8'h00 : 8'($urandom), -1, 1);
    latch_now("R11 idle bytes ignored");

    // R7/R9 oof mid-frame, wrong parity right after
    frame(8'h33, -1, 0);
    oof = 1; step(1, 0, 0, 8'h11, 0); step(1, 1, 0, 8'h22, 1); step(1, 0, 1, 8'h99, 0);
    oof = 0; step(1, 0, 0, 8'h44, 0);
    frame(8'hFF, -1, 0);
    latch_now("R9 first parity after hold ignored");
    frame(8'h01, -1, 0); latch_now("R9 checking resumes");
    // R8 lop
    frame(8'h07, -1, 0);
    lop = 1; frame(8'hFF, 2, 0); lop = 0;
    frame(8'hFF, -1, 0); frame(8'h03, -1, 0);
    latch_now("R8 lop hold then resume");

    // random mix
    for (int k = 0; k < 400; k++) begin
      blk_mode = $urandom % 2;
      oof = ($urandom % 40 == 0);
      lop = ($urandom % 40 == 0);
      frame(($urandom % 2) ? 8'h00 : 8'($urandom), ($urandom % 4 == 0) ? int'($urandom % 4) : -1, 1);
    end
    oof = 0; lop = 0;
    latch_now("R1 random run");

    // R5 saturation
    blk_mode = 0; frame(0, -1, 0); frame(0, -1, 0);
    for (int k = 0; k < 8300; k++) frame(8'hFF, -1, 0);
    latch_now("R5 saturate");
    check(m_lat == 65535, "R5 model max", m_lat, 65535);
    frame(8'h01, -1, 0); latch_now("R6 restart after saturation");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule